// File: doc/BRIEF.md
# Timed Two-Step Register Unlock Guard

This block stands in front of one safety-critical register and lets writes reach it only through a short, timed window. Software opens the window by writing a small lock control register twice. The first write sets the upper key bit alone. The second write, on the very next instruction cycle, sets the lower key bit alone. After that, write requests for the guarded register pass through for exactly three instruction cycles. Then the window shuts by itself. Requests made while the window is shut are dropped and flagged.

All sequencing counts instruction cycles, not clocks. An instruction cycle is a one-clock pulse on `cyc_stb`. Key writes and guarded write requests only count in a clock where that pulse is high. The key bits can only be written, so a read of the control register always gives zero. A new unlock attempt must come at least three instruction cycles after the previous one.

The controller has three states. `ST_IDLE` is the closed state. `ST_ARMED` means the upper key has been taken. `ST_OPEN` is the write window. The state changes as follows:
- ARM: from IDLE to ARMED, on an accepted upper-key write.
- UNLOCK: from ARMED to OPEN, on a lower-key write at the next strobe.
- ABORT: from ARMED back to IDLE, on any other strobe.
- EXPIRE: from OPEN to IDLE, on the third strobe of the window.

Top module: `keyseq_guard`

## Requirements
- R1: After reset the state is IDLE. `lock_open` and `prot_wr_en` are low and the lock is closed.
- R2: `ctl_rdata` is zero in all eight bits at all times, whatever has been written.
- R3: A control write at a strobe with bit 1 = 1 and bit 0 = 0 arms the lock. A control write at the next strobe with bit 0 = 1 and bit 1 = 0 opens it. Bits 7..2 of the written data have no effect.
- R4: A control write that has both bit 1 and bit 0 set is not a key step. A lower-key write made while the lock is not armed is also not a key step. Neither one opens the lock.
- R5: If the strobe right after arming does not carry a lower-key write, the lock returns to IDLE and stays closed. A later lower-key write does not open it.
- R6: Once open, the lock stays open for exactly three strobes, with or without guarded writes in them, and closes at the edge of the third.
- R7: An upper-key write is accepted only when at least three strobes have passed since the last accepted upper-key write. An earlier one is ignored.
- R8: `prot_wr_en` is high exactly when `prot_wr_req` and `cyc_stb` are high while the lock is open. `wr_dropped` is high exactly when they are high while it is closed.
- R9: Without a strobe, the state does not change, control writes have no effect, and neither `prot_wr_en` nor `wr_dropped` is asserted.
- R10: Control writes made while the lock is open neither extend nor shorten the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cyc_stb | input | 1 | One-clock instruction-cycle pulse |
| ctl_wr | input | 1 | Write to the lock control register |
| ctl_wdata | input | 8 | Write data for the lock control register |
| ctl_rdata | output | 8 | Read data of the lock control register (always zero) |
| prot_wr_req | input | 1 | Write request for the guarded register |
| prot_wr_en | output | 1 | Write enable passed on to the guarded register |
| wr_dropped | output | 1 | Guarded write request refused because the lock was closed |
| lock_open | output | 1 | Lock window currently open |

## Verification
The properties assume that `ctl_wr` and `prot_wr_req` only mean something in a strobe clock, and that inputs are known once reset is released. The window and retry-spacing properties do not assume any particular strobe spacing; they count strobes in their own counters. The stimulus holds each strobe for exactly one clock, leaves three idle clocks between strobes, and changes inputs one time unit after a rising edge. Unstrobed writes and requests are applied on their own clocks to show that they are ignored.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_OPEN  = 2'd2
    } kg_state_e;

endpackage

// File: rtl/keyseq_decode.sv
module keyseq_decode #(
    parameter int DATA_W = 8,
    parameter int HI_BIT = 1,
    parameter int LO_BIT = 0
) (
    input  logic              cyc_stb,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic              step_hi,
    output logic              step_lo
);

    logic key_hi;
    logic key_lo;
    logic wr_now;
    logic unused_rest;

    assign key_hi = ctl_wdata[HI_BIT];
    assign key_lo = ctl_wdata[LO_BIT];
    assign wr_now = ctl_wr & cyc_stb;

    // Exactly one key bit per step; any other data bit is a don't-care.
    assign step_hi = wr_now &  key_hi & ~key_lo;
    assign step_lo = wr_now & ~key_hi &  key_lo;

    assign unused_rest = ^ctl_wdata;

endmodule

// File: rtl/keyseq_spacer.sv
module keyseq_spacer #(
    parameter int GAP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic attempt,
    output logic gap_ok
);

    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_V = GAP_W'(GAP_CYC);
    localparam logic [GAP_W-1:0] ONE_V = GAP_W'(1);

    logic [GAP_W-1:0] since_q;

    // Counts strobes since the last accepted attempt, saturating at GAP_CYC.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= GAP_V;
        end else if (attempt) begin
            since_q <= ONE_V;
        end else if (cyc_stb && (since_q != GAP_V)) begin
            since_q <= since_q + ONE_V;
        end
    end

    assign gap_ok = (since_q == GAP_V);

endmodule

// File: rtl/keyseq_fsm.sv
module keyseq_fsm
    import keyseq_pkg::*;
#(
    parameter int WIN_CYC = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cyc_stb,
    input  logic      step_hi,
    input  logic      step_lo,
    input  logic      gap_ok,
    input  logic      prot_wr_req,
    output kg_state_e state,
    output logic      attempt,
    output logic      lock_open,
    output logic      prot_wr_en,
    output logic      wr_dropped
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);

    kg_state_e        st_q;
    kg_state_e        st_d;
    logic [WIN_W-1:0] win_q;

    assign attempt = (st_q == ST_IDLE) & step_hi & gap_ok;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (attempt) st_d = ST_ARMED;                 // ARM
            end
            ST_ARMED: begin
                if (cyc_stb) st_d = step_lo ? ST_OPEN         // UNLOCK
                                            : ST_IDLE;        // ABORT
            end
            ST_OPEN: begin
                if (cyc_stb && (win_q == WIN_LAST)) st_d = ST_IDLE;  // EXPIRE
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != ST_OPEN) begin
                win_q <= '0;
            end else if (cyc_stb) begin
                win_q <= win_q + WIN_ONE;
            end
        end
    end

    always_comb begin
        lock_open  = (st_q == ST_OPEN);
        prot_wr_en = prot_wr_req & cyc_stb &  lock_open;
        wr_dropped = prot_wr_req & cyc_stb & ~lock_open;
    end

    assign state = st_q;

endmodule

// File: rtl/keyseq_guard.sv
module keyseq_guard
    import keyseq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int HI_BIT  = 1,
    parameter int LO_BIT  = 0,
    parameter int WIN_CYC = 3,
    parameter int GAP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    input  logic              prot_wr_req,
    output logic              prot_wr_en,
    output logic              wr_dropped,
    output logic              lock_open
);

    logic      step_hi;
    logic      step_lo;
    logic      gap_ok;
    logic      attempt;
    kg_state_e state_w;
    logic      armed_w;

    keyseq_decode #(
        .DATA_W (DATA_W),
        .HI_BIT (HI_BIT),
        .LO_BIT (LO_BIT)
    ) u_dec (
        .cyc_stb   (cyc_stb),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .step_hi   (step_hi),
        .step_lo   (step_lo)
    );

    keyseq_spacer #(
        .GAP_CYC (GAP_CYC)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb),
        .attempt (attempt),
        .gap_ok  (gap_ok)
    );

    keyseq_fsm #(
        .WIN_CYC (WIN_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_stb     (cyc_stb),
        .step_hi     (step_hi),
        .step_lo     (step_lo),
        .gap_ok      (gap_ok),
        .prot_wr_req (prot_wr_req),
        .state       (state_w),
        .attempt     (attempt),
        .lock_open   (lock_open),
        .prot_wr_en  (prot_wr_en),
        .wr_dropped  (wr_dropped)
    );

    assign armed_w   = (state_w == ST_ARMED);
    assign ctl_rdata = '0;   // key bits are write-only

endmodule

// File: rtl/keyseq_guard_chk.sv
module keyseq_guard_chk #(
    parameter int WIN_CYC = 3,
    parameter int GAP_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_stb,
    input logic ctl_wr,
    input logic key_hi,
    input logic key_lo,
    input logic prot_wr_req,
    input logic prot_wr_en,
    input logic wr_dropped,
    input logic lock_open,
    input logic armed
);

    localparam int CW = $clog2(WIN_CYC + GAP_CYC + 2);
    localparam logic [CW-1:0] WIN_V = CW'(WIN_CYC);
    localparam logic [CW-1:0] GAP_V = CW'(GAP_CYC);

    logic [CW-1:0] win_seen;
    logic [CW-1:0] since;
    logic          armed_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_seen <= '0;
        end else if (!lock_open) begin
            win_seen <= '0;
        end else if (cyc_stb) begin
            win_seen <= win_seen + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since   <= GAP_V;
            armed_d <= 1'b0;
        end else begin
            armed_d <= armed;
            if (armed && !armed_d) begin
                since <= cyc_stb ? CW'(2) : CW'(1);
            end else if (cyc_stb && (since < GAP_V)) begin
                since <= since + CW'(1);
            end
        end
    end

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr_en |-> (lock_open && prot_wr_req && cyc_stb));

    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dropped |-> (!lock_open && prot_wr_req && cyc_stb));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> ($stable(lock_open) && $stable(armed)));

    p_unlock_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_open) |-> ($past(armed) && $past(cyc_stb && ctl_wr && key_lo && !key_hi)));

    p_win_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_open |-> (win_seen < WIN_V));

    p_win_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_open) |-> (win_seen == WIN_V));

    p_retry_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(since) >= GAP_V));

endmodule

bind keyseq_guard keyseq_guard_chk #(
    .WIN_CYC (WIN_CYC),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_stb     (cyc_stb),
    .ctl_wr      (ctl_wr),
    .key_hi      (ctl_wdata[HI_BIT]),
    .key_lo      (ctl_wdata[LO_BIT]),
    .prot_wr_req (prot_wr_req),
    .prot_wr_en  (prot_wr_en),
    .wr_dropped  (wr_dropped),
    .lock_open   (lock_open),
    .armed       (armed_w)
);

// File: tb/sim_keyseq_guard.sv
`timescale 1ns/1ps
module sim_keyseq_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       prot_wr_req = 1'b0;
    logic       prot_wr_en;
    logic       wr_dropped;
    logic       lock_open;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    open;
        bit    en;
        bit    drop;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    keyseq_guard u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_stb     (cyc_stb),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ctl_rdata   (ctl_rdata),
        .prot_wr_req (prot_wr_req),
        .prot_wr_en  (prot_wr_en),
        .wr_dropped  (wr_dropped),
        .lock_open   (lock_open)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: pops one expected item per strobe clock, samples at the falling edge.
    always @(negedge clk) begin
        if (rst_n && cyc_stb) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 scoreboard empty at strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(lock_open == e.open, {e.tag, " lock_open"}, int'(lock_open), int'(e.open));
                check(prot_wr_en == e.en, {e.tag, " prot_wr_en (R8)"}, int'(prot_wr_en), int'(e.en));
                check(wr_dropped == e.drop, {e.tag, " wr_dropped (R8)"}, int'(wr_dropped), int'(e.drop));
                check(ctl_rdata == 8'h00, {e.tag, " read zero (R2)"}, int'(ctl_rdata), 0);
            end
        end
    end

    // Driver: one strobed instruction cycle, then three idle clocks.
    task automatic step(input bit wr, input logic [7:0] d, input bit req,
                        input bit e_open, input bit e_en, input bit e_drop, input string tag);
        exp_t e;
        @(posedge clk); #1;
        ctl_wr = wr; ctl_wdata = d; prot_wr_req = req; cyc_stb = 1'b1;
        e.open = e_open; e.en = e_en; e.drop = e_drop; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        cyc_stb = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00; prot_wr_req = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    // Unstrobed write/request: nothing may pass or be flagged (R9).
    task automatic nostb(input bit wr, input logic [7:0] d, input bit req, input bit e_open);
        @(posedge clk); #1;
        ctl_wr = wr; ctl_wdata = d; prot_wr_req = req;
        @(negedge clk);
        check(prot_wr_en == 1'b0, "R9 no enable without strobe", int'(prot_wr_en), 0);
        check(wr_dropped == 1'b0, "R9 no drop flag without strobe", int'(wr_dropped), 0);
        check(ctl_rdata == 8'h00, "R2 read zero after unstrobed write", int'(ctl_rdata), 0);
        @(posedge clk); #1;
        ctl_wr = 1'b0; ctl_wdata = 8'h00; prot_wr_req = 1'b0;
        @(negedge clk);
        check(lock_open == e_open, "R9 state unchanged without strobe", int'(lock_open), int'(e_open));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(lock_open == 1'b0, "R1 reset lock closed", int'(lock_open), 0);
        check(prot_wr_en == 1'b0, "R1 reset no enable", int'(prot_wr_en), 0);
        check(ctl_rdata == 8'h00, "R2 reset read zero", int'(ctl_rdata), 0);

        // Normal unlock and full window
        step(1, 8'h02, 0, 0, 0, 0, "R3 arm");
        step(1, 8'h01, 0, 0, 0, 0, "R3 unlock step");
        step(0, 8'h00, 1, 1, 1, 0, "R6 window 1");
        step(0, 8'h00, 1, 1, 1, 0, "R6 window 2 not closed early");
        step(0, 8'h00, 1, 1, 1, 0, "R6 window 3");
        step(0, 8'h00, 1, 0, 0, 1, "R6 closed after window");

        // Timeout between the two keys
        step(1, 8'h02, 0, 0, 0, 0, "R5 arm");
        step(0, 8'h00, 0, 0, 0, 0, "R5 missed strobe");
        step(1, 8'h01, 0, 0, 0, 0, "R5 late lower key");
        step(0, 8'h00, 1, 0, 0, 1, "R5 still closed");

        // Both bits in one write
        step(1, 8'h03, 0, 0, 0, 0, "R4 both bits");
        step(1, 8'h01, 0, 0, 0, 0, "R4 lower after both");
        step(0, 8'h00, 1, 0, 0, 1, "R4 both bits kept closed");

        // Wrong order, then retry spacing
        step(1, 8'h01, 0, 0, 0, 0, "R4 lower first");
        step(1, 8'h02, 0, 0, 0, 0, "R7 first attempt");
        step(0, 8'h00, 1, 0, 0, 1, "R5 abort with request");
        step(1, 8'h02, 0, 0, 0, 0, "R7 early retry");
        step(1, 8'h01, 0, 0, 0, 0, "R7 lower after early retry");
        step(0, 8'h00, 1, 0, 0, 1, "R7 early retry rejected");
        step(1, 8'h02, 0, 0, 0, 0, "R7 spaced retry");
        step(1, 8'h01, 0, 0, 0, 0, "R7 spaced unlock");
        step(0, 8'h00, 1, 1, 1, 0, "R7 spaced retry opens");
        step(0, 8'h00, 0, 1, 0, 0, "R6 idle window strobe");
        step(0, 8'h00, 0, 1, 0, 0, "R6 last window strobe");
        step(0, 8'h00, 1, 0, 0, 1, "R6 closed again");

        // Strobe qualification, upper data bits, writes while open
        nostb(1, 8'h02, 0, 1'b0);
        step(1, 8'h01, 0, 0, 0, 0, "R9 unstrobed arm ignored");
        nostb(0, 8'h00, 1, 1'b0);
        step(1, 8'hFE, 0, 0, 0, 0, "R3 arm with upper bits set");
        step(1, 8'hFD, 0, 0, 0, 0, "R3 unlock with upper bits set");
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(lock_open == 1'b1, "R9 window held without strobes", int'(lock_open), 1);
        nostb(0, 8'h00, 1, 1'b1);
        step(0, 8'h00, 1, 1, 1, 0, "R3 upper bits ignored, open");
        step(1, 8'h02, 0, 1, 0, 0, "R10 key write while open");
        step(1, 8'h01, 1, 1, 1, 0, "R10 lower write while open");
        step(0, 8'h00, 1, 0, 0, 1, "R10 window not extended");

        repeat (4) @(posedge clk);
        check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule